// File: doc/BRIEF.md
# Masked clock-gate and reset controller

This block holds the gate enables for a set of module clocks and the active-low release lines for a set of module resets. Software drives both through 32-bit registers on a simple address / write-data / write-strobe / read-data bus. Every control write carries its own per-bit write mask in the upper half-word, so one bus write can flip any subset of sixteen controls and leave the others alone. A read-modify-write sequence is never needed.

The controls are not read back as settled state. Each clock group and each reset group has a monitor register. It samples status lines returned by the clock and reset logic outside the block, and those lines lag the controls by some number of cycles. Software polls a monitor register until the running clock or the released reset shows up there. The register windows sit at fixed byte offsets. Each window holds up to 64 registers, and the address width must be at least 12 bits. Address bits 1:0 are ignored.

Top module: `cgr_ctrl`

## Requirements
- R1: After reset every clock gate enable is 0 (off) and every reset release line is 0 (reset asserted). Control registers read 0, clock monitor registers read 0, and reset monitor registers read 0x0000FFFF.
- R2: In a control write, bits 31:16 form a mask. Bit k of the control (k = 0..15) takes write-data bit k only when mask bit k+16 is 1 in the same write. Every other control bit keeps its value.
- R3: Clock control register n is at byte offset 0x600 + 4*n. Its bit k drives `clk_gate_en[16*n+k]`, where 1 means the clock runs. A write shows on the output from the clock edge that accepts it.
- R4: Reset control register n is at byte offset 0x900 + 4*n. Its bit k drives `mod_rst_n[16*n+k]` and is active low: writing 0 under the mask asserts the reset, and writing 1 under the mask releases it.
- R5: Clock monitor register n at byte offset 0x800 + 4*n returns, in bits 15:0, `clk_run_mon[16*n+15:16*n]` as sampled at the previous clock edge. A 1 means that clock is running.
- R6: Reset monitor register n at byte offset 0xA00 + 4*n returns, in bits 15:0, `rst_busy_mon[16*n+15:16*n]` as sampled at the previous clock edge. A 1 means the reset is still asserted and 0 means the release has taken effect.
- R7: Reads of any control or monitor register return 0 in bits 31:16.
- R8: Writes to monitor offsets change no control bit and no monitor value.
- R9: Reads of unmapped offsets return 0, and writes to them change nothing. This covers offsets that lie inside a window but past the configured register count. Address bits 1:0 do not take part in decoding.
- R10: A flat reset number id selects reset register id/16, bit id%16, and drives `mod_rst_n[id]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data: mask in 31:16, values in 15:0 |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| clk_gate_en | output | 16*CLK_REGS | Module clock gate enables, 1 = run |
| mod_rst_n | output | 16*RST_REGS | Module reset release lines, 0 = in reset |
| clk_run_mon | input | 16*CLK_REGS | Running status returned by the clock gates |
| rst_busy_mon | input | 16*RST_REGS | Reset-active status returned by the reset logic |

## Verification
The bench builds the block with two clock registers and two reset registers. With that count, offsets 0x608 and 0x908 lie inside a window yet past its last register, so the out-of-range unmapped case can be reached. Bit 15 of the second reset register is flat reset number 31, which exercises the top end of the flat mapping. The bench drives the monitor inputs from its own three-cycle delay line, so the exact cycle at which a monitor register first shows a new control value can be checked, both one cycle early and on time.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

  localparam int unsigned HALF_W = 16;
  localparam int unsigned BUS_W  = 32;

  // Byte offsets of the four register windows
  localparam logic [31:0] CLK_CTRL_BASE = 32'h0000_0600;
  localparam logic [31:0] CLK_MON_BASE  = 32'h0000_0800;
  localparam logic [31:0] RST_CTRL_BASE = 32'h0000_0900;
  localparam logic [31:0] RST_MON_BASE  = 32'h0000_0A00;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CLK_CTRL,
    SEL_CLK_MON,
    SEL_RST_CTRL,
    SEL_RST_MON
  } sel_kind_e;

  // Apply one masked write: mask in the upper half, values in the lower half
  function automatic logic [HALF_W-1:0] masked_merge(
    input logic [HALF_W-1:0] cur,
    input logic [BUS_W-1:0]  wd
  );
    logic [HALF_W-1:0] msk;
    msk = wd[BUS_W-1:HALF_W];
    return (cur & ~msk) | (wd[HALF_W-1:0] & msk);
  endfunction

endpackage

// File: rtl/cgr_decode.sv
module cgr_decode
  import cgr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CLK_REGS = 2,
  parameter int unsigned RST_REGS = 2,
  parameter int unsigned IDX_W    = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_kind_e         kind,
  output logic [IDX_W-1:0]  idx
);

  logic [31:0] word_addr;
  logic [31:0] offset_words;

  assign word_addr = 32'(addr) & ~32'h3;

  function automatic logic in_window(
    input logic [31:0] a,
    input logic [31:0] base,
    input int unsigned count
  );
    return (a >= base) && (((a - base) >> 2) < 32'(count));
  endfunction

  always_comb begin
    kind         = SEL_NONE;
    offset_words = '0;
    if (in_window(word_addr, CLK_CTRL_BASE, CLK_REGS)) begin
      kind         = SEL_CLK_CTRL;
      offset_words = (word_addr - CLK_CTRL_BASE) >> 2;
    end else if (in_window(word_addr, CLK_MON_BASE, CLK_REGS)) begin
      kind         = SEL_CLK_MON;
      offset_words = (word_addr - CLK_MON_BASE) >> 2;
    end else if (in_window(word_addr, RST_CTRL_BASE, RST_REGS)) begin
      kind         = SEL_RST_CTRL;
      offset_words = (word_addr - RST_CTRL_BASE) >> 2;
    end else if (in_window(word_addr, RST_MON_BASE, RST_REGS)) begin
      kind         = SEL_RST_MON;
      offset_words = (word_addr - RST_MON_BASE) >> 2;
    end
  end

  assign idx = offset_words[IDX_W-1:0];

endmodule

// File: rtl/cgr_masked_bank.sv
module cgr_masked_bank
  import cgr_pkg::*;
#(
  parameter int unsigned       NREGS   = 2,
  parameter logic [HALF_W-1:0] RST_VAL = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREGS-1:0]          wr_sel,
  input  logic [BUS_W-1:0]          wdata,
  output logic [NREGS*HALF_W-1:0]   ctrl_flat
);

  logic [HALF_W-1:0] ctrl_q [NREGS];
  logic [HALF_W-1:0] ctrl_d [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    // next-state
    always_comb begin
      ctrl_d[g] = masked_merge(ctrl_q[g], wdata);
    end

    // state, clock-enabled by the register's write select
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[g] <= RST_VAL;
      end else if (wr_sel[g]) begin
        ctrl_q[g] <= ctrl_d[g];
      end
    end

    assign ctrl_flat[g*HALF_W +: HALF_W] = ctrl_q[g];

    // R2: bits outside the mask keep their value
    a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[g] |=> (((ctrl_q[g] ^ $past(ctrl_q[g])) & ~$past(wdata[BUS_W-1:HALF_W])) == '0));

    // R2: bits inside the mask take the written value
    a_r2_masked_take: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel[g] |=> (((ctrl_q[g] ^ $past(wdata[HALF_W-1:0])) & $past(wdata[BUS_W-1:HALF_W])) == '0));

    // R2: no write selected, no change
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sel[g] |=> $stable(ctrl_q[g]));
  end

endmodule

// File: rtl/cgr_mon_capture.sv
module cgr_mon_capture
  import cgr_pkg::*;
#(
  parameter int unsigned       NREGS   = 2,
  parameter logic [HALF_W-1:0] RST_VAL = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NREGS*HALF_W-1:0]   mon_in,
  output logic [NREGS*HALF_W-1:0]   mon_flat
);

  logic [HALF_W-1:0] mon_q [NREGS];
  logic [HALF_W-1:0] mon_d [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_mon
    always_comb begin
      mon_d[g] = mon_in[g*HALF_W +: HALF_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mon_q[g] <= RST_VAL;
      end else begin
        mon_q[g] <= mon_d[g];
      end
    end

    assign mon_flat[g*HALF_W +: HALF_W] = mon_q[g];

    // R5 / R6: a monitor register shows its status lines one edge later
    a_r5_capture_lag: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (mon_q[g] == $past(mon_in[g*HALF_W +: HALF_W])));
  end

endmodule

// File: rtl/cgr_ctrl.sv
module cgr_ctrl
  import cgr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CLK_REGS = 2,
  parameter int unsigned RST_REGS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  input  logic                         bus_wr,
  output logic [31:0]                  bus_rdata,
  output logic [CLK_REGS*16-1:0]       clk_gate_en,
  output logic [RST_REGS*16-1:0]       mod_rst_n,
  input  logic [CLK_REGS*16-1:0]       clk_run_mon,
  input  logic [RST_REGS*16-1:0]       rst_busy_mon
);

  localparam int unsigned NMAX  = (CLK_REGS > RST_REGS) ? CLK_REGS : RST_REGS;
  localparam int unsigned IDX_W = (NMAX > 1) ? $clog2(NMAX) : 1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // Address decode
  sel_kind_e        sel_kind;
  logic [IDX_W-1:0] sel_idx;

  cgr_decode #(
    .ADDR_W  (ADDR_W),
    .CLK_REGS(CLK_REGS),
    .RST_REGS(RST_REGS),
    .IDX_W   (IDX_W)
  ) u_decode (
    .addr(bus_addr),
    .kind(sel_kind),
    .idx (sel_idx)
  );

  // Per-register write selects
  logic [CLK_REGS-1:0] clk_wsel;
  logic [RST_REGS-1:0] rst_wsel;

  for (genvar g = 0; g < CLK_REGS; g++) begin : g_clk_sel
    assign clk_wsel[g] = bus_wr && (sel_kind == SEL_CLK_CTRL) && (sel_idx == IDX_W'(g));
  end
  for (genvar g = 0; g < RST_REGS; g++) begin : g_rst_sel
    assign rst_wsel[g] = bus_wr && (sel_kind == SEL_RST_CTRL) && (sel_idx == IDX_W'(g));
  end

  // Control banks: clocks off, resets asserted
  logic [CLK_REGS*16-1:0] clk_ctrl_flat;
  logic [RST_REGS*16-1:0] rst_ctrl_flat;

  cgr_masked_bank #(.NREGS(CLK_REGS), .RST_VAL(16'h0000)) u_clk_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_sel   (clk_wsel),
    .wdata    (bus_wdata),
    .ctrl_flat(clk_ctrl_flat)
  );

  cgr_masked_bank #(.NREGS(RST_REGS), .RST_VAL(16'h0000)) u_rst_bank (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_sel   (rst_wsel),
    .wdata    (bus_wdata),
    .ctrl_flat(rst_ctrl_flat)
  );

  // Monitor capture: clocks not running, resets busy
  logic [CLK_REGS*16-1:0] clk_mon_flat;
  logic [RST_REGS*16-1:0] rst_mon_flat;

  cgr_mon_capture #(.NREGS(CLK_REGS), .RST_VAL(16'h0000)) u_clk_mon (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .mon_in  (clk_run_mon),
    .mon_flat(clk_mon_flat)
  );

  cgr_mon_capture #(.NREGS(RST_REGS), .RST_VAL(16'hFFFF)) u_rst_mon (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .mon_in  (rst_busy_mon),
    .mon_flat(rst_mon_flat)
  );

  assign clk_gate_en = clk_ctrl_flat;
  assign mod_rst_n   = rst_ctrl_flat;

  // Read path
  always_comb begin
    bus_rdata = '0;
    case (sel_kind)
      SEL_CLK_CTRL: bus_rdata = {16'h0000, clk_ctrl_flat[16*sel_idx +: 16]};
      SEL_CLK_MON:  bus_rdata = {16'h0000, clk_mon_flat[16*sel_idx +: 16]};
      SEL_RST_CTRL: bus_rdata = {16'h0000, rst_ctrl_flat[16*sel_idx +: 16]};
      SEL_RST_MON:  bus_rdata = {16'h0000, rst_mon_flat[16*sel_idx +: 16]};
      default:      bus_rdata = '0;
    endcase
  end

  // R8: monitor writes leave every control untouched
  a_r8_mon_write_ignored: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && ((sel_kind == SEL_CLK_MON) || (sel_kind == SEL_RST_MON)))
    |=> ($stable(clk_gate_en) && $stable(mod_rst_n)));

  // R9: unmapped writes leave every control untouched
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && (sel_kind == SEL_NONE))
    |=> ($stable(clk_gate_en) && $stable(mod_rst_n)));

endmodule

// File: tb/test_cgr_ctrl.sv
module test_cgr_ctrl;

  localparam int unsigned NC        = 2;
  localparam int unsigned NR        = 2;
  localparam int unsigned MON_DELAY = 3;

  logic              clk;
  logic              rst_n;
  logic [11:0]       bus_addr;
  logic [31:0]       bus_wdata;
  logic              bus_wr;
  logic [31:0]       bus_rdata;
  logic [NC*16-1:0]  clk_gate_en;
  logic [NR*16-1:0]  mod_rst_n;
  logic [NC*16-1:0]  clk_run_mon;
  logic [NR*16-1:0]  rst_busy_mon;

  int n_tests;
  int n_fail;
  bit cmp_on;

  cgr_ctrl #(.ADDR_W(12), .CLK_REGS(NC), .RST_REGS(NR)) i_cgr_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .clk_gate_en (clk_gate_en),
    .mod_rst_n   (mod_rst_n),
    .clk_run_mon (clk_run_mon),
    .rst_busy_mon(rst_busy_mon)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Environment: status lines lag the controls by MON_DELAY cycles
  logic [NC*16-1:0] clk_dl [MON_DELAY];
  logic [NR*16-1:0] rst_dl [MON_DELAY];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MON_DELAY; i++) begin
        clk_dl[i] <= '0;
        rst_dl[i] <= '1;
      end
    end else begin
      clk_dl[0] <= clk_gate_en;
      rst_dl[0] <= ~mod_rst_n;
      for (int i = 1; i < MON_DELAY; i++) begin
        clk_dl[i] <= clk_dl[i-1];
        rst_dl[i] <= rst_dl[i-1];
      end
    end
  end
  assign clk_run_mon  = clk_dl[MON_DELAY-1];
  assign rst_busy_mon = rst_dl[MON_DELAY-1];

  // Reference model of the control state
  logic [15:0] m_clk [NC];
  logic [15:0] m_rst [NR];

  initial begin
    for (int i = 0; i < NC; i++) m_clk[i] = '0;
    for (int i = 0; i < NR; i++) m_rst[i] = '0;
  end

  always @(posedge clk) begin
    logic [11:0] wa;
    wa = {bus_addr[11:2], 2'b00};
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) m_clk[i] = '0;
      for (int i = 0; i < NR; i++) m_rst[i] = '0;
    end else if (bus_wr) begin
      for (int i = 0; i < NC; i++) begin
        if (wa == 12'(32'h600 + 4*i)) begin
          for (int b = 0; b < 16; b++)
            if (bus_wdata[b+16]) m_clk[i][b] = bus_wdata[b];
        end
      end
      for (int i = 0; i < NR; i++) begin
        if (wa == 12'(32'h900 + 4*i)) begin
          for (int b = 0; b < 16; b++)
            if (bus_wdata[b+16]) m_rst[i][b] = bus_wdata[b];
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Outputs against the model on every clock
  always @(negedge clk) begin
    #2;
    if (cmp_on) begin
      for (int i = 0; i < NC; i++)
        check(clk_gate_en[16*i +: 16] == m_clk[i], "R3 clock gate outputs",
              32'(clk_gate_en[16*i +: 16]), 32'(m_clk[i]));
      for (int i = 0; i < NR; i++)
        check(mod_rst_n[16*i +: 16] == m_rst[i], "R4 reset release outputs",
              32'(mod_rst_n[16*i +: 16]), 32'(m_rst[i]));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    n_tests   = 0;
    n_fail    = 0;
    cmp_on    = 1'b0;
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_wr    = 1'b0;
    idle(3);
    // R1: reset state at the ports
    check(clk_gate_en == '0, "R1 gates off in reset", 32'(clk_gate_en), 32'h0);
    check(mod_rst_n == '0, "R1 resets asserted in reset", 32'(mod_rst_n), 32'h0);
    rst_n = 1'b1;
    idle(5);
    cmp_on = 1'b1;

    rd(12'h600, 32'h0, "R1 clock ctrl 0 after reset");
    rd(12'h604, 32'h0, "R1 clock ctrl 1 after reset");
    rd(12'h900, 32'h0, "R1 reset ctrl 0 after reset");
    rd(12'h800, 32'h0, "R1 clock monitor after reset");
    rd(12'hA00, 32'h0000FFFF, "R1 R6 reset monitor 0 after reset");
    rd(12'hA04, 32'h0000FFFF, "R1 R6 reset monitor 1 after reset");

    // R2 R3 R7: masked set of the low byte
    wr(12'h600, 32'h00FF_FFFF);
    rd(12'h600, 32'h0000_00FF, "R2 R7 masked set");
    // R5: monitor lag of MON_DELAY+1 cycles
    rd(12'h800, 32'h0, "R5 monitor not yet updated");
    idle(MON_DELAY);
    rd(12'h800, 32'h0, "R5 monitor one cycle early");
    idle(1);
    rd(12'h800, 32'h0000_00FF, "R5 monitor shows running clocks");

    // R2: masked clear and an empty mask
    wr(12'h600, 32'h0003_0000);
    rd(12'h600, 32'h0000_00FC, "R2 masked clear");
    wr(12'h604, 32'h0000_FFFF);
    rd(12'h604, 32'h0, "R2 empty mask changes nothing");
    wr(12'h604, 32'hA5A5_FFFF);
    rd(12'h604, 32'h0000_A5A5, "R2 R3 mixed pattern");

    // R4 R10: release resets 16 and 31
    wr(12'h904, 32'h8001_8001);
    rd(12'h904, 32'h0000_8001, "R4 reset release readback");
    check(mod_rst_n[31] == 1'b1, "R10 flat id 31 released", 32'(mod_rst_n[31]), 32'h1);
    check(mod_rst_n[16] == 1'b1, "R10 flat id 16 released", 32'(mod_rst_n[16]), 32'h1);
    check(mod_rst_n[17] == 1'b0, "R10 flat id 17 held", 32'(mod_rst_n[17]), 32'h0);
    idle(MON_DELAY + 2);
    rd(12'hA04, 32'h0000_7FFE, "R6 reset monitor after release");
    wr(12'h904, 32'h0001_0000);
    rd(12'h904, 32'h0000_8000, "R4 reassert reset 16");
    check(mod_rst_n[16] == 1'b0, "R4 R10 flat id 16 asserted", 32'(mod_rst_n[16]), 32'h0);

    // R8: writes to monitors ignored
    wr(12'h800, 32'hFFFF_FFFF);
    wr(12'hA00, 32'hFFFF_0000);
    idle(MON_DELAY + 2);
    rd(12'h800, 32'h0000_00FC, "R8 clock monitor unchanged");
    rd(12'hA00, 32'h0000_FFFF, "R8 reset monitor unchanged");
    rd(12'h600, 32'h0000_00FC, "R8 clock ctrl unchanged");
    rd(12'h900, 32'h0, "R8 reset ctrl unchanged");

    // R9: unmapped offsets
    wr(12'h608, 32'hFFFF_FFFF);
    wr(12'h90C, 32'hFFFF_FFFF);
    rd(12'h608, 32'h0, "R9 past-count clock offset reads zero");
    rd(12'h908, 32'h0, "R9 past-count reset offset reads zero");
    rd(12'h400, 32'h0, "R9 unmapped offset reads zero");
    rd(12'h600, 32'h0000_00FC, "R9 clock ctrl 0 untouched");
    rd(12'h604, 32'h0000_A5A5, "R9 clock ctrl 1 untouched");
    rd(12'h904, 32'h0000_8000, "R9 reset ctrl 1 untouched");
    rd(12'h601, 32'h0000_00FC, "R9 low address bits ignored");

    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule